// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block is a read-only instruction cache of 4 KB that sits between an instruction fetch unit and a slow external bus. It holds 256 lines of four 32-bit words, and both the index and the tag come from the 32-bit physical address. Because the tags are physical, a context switch needs no flush, and any address in the 4 GB space can be cached. A fetch that hits is answered in the same cycle. A fetch that misses stalls. The cache then asks the bus side for the whole aligned 16-byte line as one quad-word burst, writes the four returned words, marks the line valid and serves the stalled fetch.

The requester holds `fetch_req` with a stable `fetch_addr` until it sees `fetch_ack`. The bus side answers one `fill_req` pulse with exactly four `fill_valid` beats, word 0 first. The beats may have idle cycles between them. A one-cycle `inval_all` pulse clears every valid bit, one line per cycle, while `inval_busy` is high. If the pulse comes during a fill, the clear starts when the fill ends.

Top module: `icache_dm`

## Requirements
- R1: A fetch whose line is valid and whose tag (address bits [31:12]) matches the line selected by bits [11:4] asserts `fetch_ack` in the same cycle. `fetch_data` then holds the word that bits [3:2] select.
- R2: A fetch that misses while the cache is idle raises `fill_req` for exactly one cycle, in the next cycle. `fill_addr` holds the fetch address with bits [3:0] cleared.
- R3: Fill beats are written to word 0, 1, 2 and 3 of the line in that order, and idle cycles between beats are allowed. No fetch is acknowledged while a fill is in progress.
- R4: The line becomes valid only when the fourth beat is accepted. A stalled fetch that is held is acknowledged, with the correct word, in the cycle after that beat.
- R5: Two addresses with the same bits [11:4] and different tags share one line, so filling one evicts the other.
- R6: Addresses at both ends of the 4 GB space, including 0x0000_0000 and 0xFFFF_FFFC, are cached and returned correctly.
- R7: When `inval_all` is sampled in the idle state, `inval_busy` is high for exactly 256 cycles starting in the next cycle. No fetch is acknowledged during that time, and afterwards every address misses.
- R8: An `inval_all` pulse that arrives during a fill is held until the fill completes. The clear then starts instead of a return to idle, so the held fetch is not acknowledged and the line just filled is invalid afterwards.
- R9: `fill_valid` beats that arrive while no fill is in progress are ignored and change no cached word.
- R10: After reset, `fill_req`, `inval_busy` and `fetch_ack` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 32 | Physical byte address of the fetch |
| fetch_ack | output | 1 | Hit: `fetch_data` is valid this cycle |
| fetch_data | output | 32 | Instruction word returned |
| fill_req | output | 1 | One-cycle line-fill request pulse |
| fill_addr | output | 32 | Line-aligned address of the requested fill |
| fill_valid | input | 1 | A fill beat is present on `fill_data` |
| fill_data | input | 32 | Fill word, in ascending word order |
| inval_all | input | 1 | Request to invalidate every line |
| inval_busy | output | 1 | High while the invalidate sweep runs |

## Verification
The bench fills lines from a mid-line fetch address and with a gap between beats. A design that wrote beats to the wrong word, or counted idle cycles as beats, would return the wrong words on the later hits. It forces an eviction through two tags that share one index and caches lines at address zero and at the top of the space, which catches a swapped index/tag slice or a truncated tag compare. It counts the invalidate busy window and raises a fetch inside it, and it pulses invalidate in the middle of a fill. A design that dropped the deferred clear would acknowledge the held fetch and keep the line valid. Stray fill beats sent while the cache is idle would corrupt the most recently filled line in a design that accepted them.

// File: rtl/icache_pkg.sv
package icache_pkg;

    // Controller phases: serving lookups, collecting a line, sweeping valid bits
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_CLEAR = 2'd2
    } ic_state_e;

endpackage

// File: rtl/icache_store.sv
module icache_store #(
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    parameter int TAG_W  = 20,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tag_set,
    input  logic [TAG_W-1:0]  tag_val,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);

    logic [WORD_W-1:0] data_q [LINES][WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_d, valid_q;

    // Valid bits are the only reset state; the arrays need none
    always_comb begin
        valid_d = valid_q;
        if (tag_set) valid_d[wr_idx]  = 1'b1;
        if (clr_en)  valid_d[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Array write ports (one word per cycle, tag written with the last beat)
    always_ff @(posedge clk) begin
        if (wr_en)   data_q[wr_idx][wr_word] <= wr_data;
        if (tag_set) tag_q[wr_idx]           <= tag_val;
    end

    assign rd_data  = data_q[rd_idx][rd_word];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = $clog2(WORDS * WORD_W / 8),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [LINE_W-1:0] fetch_line,
    output logic              fetch_ack,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              rd_valid,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic              inval_all,
    output logic              inval_busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WSEL_W-1:0] wr_word,
    output logic              tag_set,
    output logic [TAG_W-1:0]  tag_val,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx
);

    typedef struct packed {
        ic_state_e         st;
        logic [IDX_W-1:0]  clr;
        logic [WSEL_W-1:0] beat;
        logic [LINE_W-1:0] line;
        logic              req;
        logic              pend;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, clr: '0, beat: '0, line: '0,
                                 req: 1'b0, pend: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic hit;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.req = 1'b0;
        hit       = rd_valid && (rd_tag == fetch_line[LINE_W-1 -: TAG_W]);
        fetch_ack = (ctl_q.st == ST_IDLE) && fetch_req && hit;
        wr_en     = 1'b0;
        tag_set   = 1'b0;
        clr_en    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (inval_all) begin
                    ctl_d.st  = ST_CLEAR;
                    ctl_d.clr = '0;
                end else if (fetch_req && !hit) begin
                    ctl_d.st   = ST_FILL;
                    ctl_d.req  = 1'b1;
                    ctl_d.beat = '0;
                    ctl_d.line = fetch_line;
                end
            end
            ST_FILL: begin
                if (inval_all) ctl_d.pend = 1'b1;
                if (fill_valid) begin
                    wr_en      = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == WSEL_W'(WORDS - 1)) begin
                        tag_set = 1'b1;
                        if (ctl_q.pend || inval_all) begin
                            ctl_d.st   = ST_CLEAR;
                            ctl_d.clr  = '0;
                            ctl_d.pend = 1'b0;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_CLEAR: begin
                clr_en    = 1'b1;
                ctl_d.clr = ctl_q.clr + 1'b1;
                if (ctl_q.clr == IDX_W'(LINES - 1)) ctl_d.st = ST_IDLE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign wr_idx     = ctl_q.line[IDX_W-1:0];
    assign wr_word    = ctl_q.beat;
    assign tag_val    = ctl_q.line[LINE_W-1 -: TAG_W];
    assign clr_idx    = ctl_q.clr;
    assign fill_req   = ctl_q.req;
    assign fill_addr  = {ctl_q.line, {OFF_W{1'b0}}};
    assign inval_busy = (ctl_q.st == ST_CLEAR);

    // Length of the current busy run, kept only for the sweep-length check
    logic [IDX_W:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_run_q <= '0;
        else if (inval_busy) busy_run_q <= busy_run_q + 1'b1;
        else                 busy_run_q <= '0;
    end

    p_fill_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req);

    p_fill_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> ($past(fetch_req) && !$past(fetch_ack)));

    p_fill_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (fill_addr[ADDR_W-1:OFF_W] == $past(fetch_line)));

    p_busy_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inval_busy |-> !fetch_ack);

    p_sweep_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inval_busy) |-> (busy_run_q == (IDX_W + 1)'(LINES)));

endmodule

// File: rtl/icache_dm.sv
module icache_dm #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ack,
    output logic [WORD_W-1:0] fetch_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              inval_all,
    output logic              inval_busy
);

    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int OFF_W  = WSEL_W + BSEL_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic [TAG_W-1:0]  rd_tag, tag_val;
    logic              rd_valid, wr_en, tag_set, clr_en;
    logic [IDX_W-1:0]  wr_idx, clr_idx;
    logic [WSEL_W-1:0] wr_word;
    logic              byte_sel_unused;

    // Byte offset within a word plays no part in an instruction fetch
    assign byte_sel_unused = ^fetch_addr[BSEL_W-1:0];

    icache_store #(
        .LINES (LINES),
        .WORDS (WORDS),
        .WORD_W(WORD_W),
        .TAG_W (TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_addr[OFF_W +: IDX_W]),
        .rd_word (fetch_addr[BSEL_W +: WSEL_W]),
        .rd_data (fetch_data),
        .rd_tag  (rd_tag),
        .rd_valid(rd_valid),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .wr_data (fill_data),
        .tag_set (tag_set),
        .tag_val (tag_val),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    icache_ctrl #(
        .ADDR_W(ADDR_W),
        .LINES (LINES),
        .WORDS (WORDS),
        .WORD_W(WORD_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .fetch_line(fetch_addr[ADDR_W-1:OFF_W]),
        .fetch_ack (fetch_ack),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .fill_req  (fill_req),
        .fill_addr (fill_addr),
        .fill_valid(fill_valid),
        .inval_all (inval_all),
        .inval_busy(inval_busy),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .tag_set   (tag_set),
        .tag_val   (tag_val),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

endmodule

// File: tb/sim_icache_dm.sv
module sim_icache_dm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ack;
    logic [31:0] fetch_data;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        inval_all = 1'b0;
    logic        inval_busy;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    icache_dm u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .fetch_ack (fetch_ack),
        .fetch_data(fetch_data),
        .fill_req  (fill_req),
        .fill_addr (fill_addr),
        .fill_valid(fill_valid),
        .fill_data (fill_data),
        .inval_all (inval_all),
        .inval_busy(inval_busy)
    );

    // Backing memory contents, a function of the word address
    function automatic logic [31:0] mw(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Four beats, word 0 first, with an idle cycle before word 2 (R3)
    task automatic serve_fill(input logic [31:0] line);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 2) begin
                fill_valid = 1'b0;
                #1 chk(!fetch_ack, "R3 no ack in gap", 32'(fetch_ack), 0);
                @(negedge clk);
            end
            fill_valid = 1'b1;
            fill_data  = mw(line + 32'(4 * k));
            #1 chk(!fetch_ack, "R3 no ack during fill", 32'(fetch_ack), 0);
            if (k == 0) chk(!fill_req, "R2 fill_req one cycle", 32'(fill_req), 0);
        end
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fetch_miss(input logic [31:0] a, input string req);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        #1 chk(!fetch_ack, req, 32'(fetch_ack), 0);
        @(negedge clk);
        #1 chk(fill_req, "R2 fill_req after miss", 32'(fill_req), 1);
        chk(fill_addr == {a[31:4], 4'h0}, "R2 fill_addr", fill_addr, {a[31:4], 4'h0});
        serve_fill({a[31:4], 4'h0});
        #1 chk(fetch_ack, "R4 ack after fourth beat", 32'(fetch_ack), 1);
        chk(fetch_data == mw(a), "R4 stalled word", fetch_data, mw(a));
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic fetch_hit(input logic [31:0] a, input string req);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        #1 chk(fetch_ack, req, 32'(fetch_ack), 1);
        chk(fetch_data == mw(a), req, fetch_data, mw(a));
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1 chk(!fill_req, "R10 fill_req after reset", 32'(fill_req), 0);
        chk(!inval_busy, "R10 busy after reset", 32'(inval_busy), 0);
        chk(!fetch_ack, "R10 ack after reset", 32'(fetch_ack), 0);
        fetch_miss(32'h0000_0100, "R10 first fetch misses");
    endtask

    task automatic t_line;
        fetch_miss(32'h0000_1238, "R1 cold miss mid-line");
        for (int k = 0; k < 4; k++)
            fetch_hit(32'h0000_1230 + 32'(4 * k), "R1 R3 word of filled line");
    endtask

    task automatic t_conflict;
        fetch_miss(32'h0000_2234, "R5 same index other tag misses");
        fetch_miss(32'h0000_1230, "R5 evicted line misses");
        fetch_hit(32'h0000_123C, "R5 refilled line hits");
    endtask

    task automatic t_extremes;
        fetch_miss(32'hFFFF_FFFC, "R6 top of space misses");
        fetch_hit(32'hFFFF_FFF0, "R6 top line hits");
        fetch_miss(32'h0000_0004, "R6 bottom of space misses");
        fetch_hit(32'hFFFF_FFF4, "R6 top line still hits");
    endtask

    task automatic t_stray;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        fill_valid = 1'b0;
        #1 chk(!fill_req, "R9 no fill from stray beats", 32'(fill_req), 0);
        for (int k = 0; k < 4; k++)
            fetch_hit(32'h0000_0000 + 32'(4 * k), "R9 line unchanged by stray beats");
    endtask

    task automatic t_inval;
        int n = 0;
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        #1;
        while (inval_busy && n < 1000) begin
            n++;
            if (n == 10) begin
                fetch_req  = 1'b1;
                fetch_addr = 32'hFFFF_FFF0;
            end
            if (n == 11) begin
                chk(!fetch_ack, "R7 no ack while busy", 32'(fetch_ack), 0);
                fetch_req = 1'b0;
            end
            @(negedge clk);
            #1;
        end
        chk(n == 256, "R7 busy length", 32'(n), 256);
        fetch_miss(32'hFFFF_FFF0, "R7 miss after invalidate");
        fetch_miss(32'h0000_0008, "R7 second miss after invalidate");
    endtask

    task automatic t_defer;
        int n = 0;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_4448;
        @(negedge clk);
        #1 chk(fill_req, "R8 fill request", 32'(fill_req), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = mw(32'h0000_4440 + 32'(4 * k));
            inval_all  = (k == 1);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        inval_all  = 1'b0;
        #1 chk(!fetch_ack, "R8 held fetch not acked", 32'(fetch_ack), 0);
        chk(inval_busy, "R8 deferred clear started", 32'(inval_busy), 1);
        fetch_req = 1'b0;
        while (inval_busy && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == 256, "R8 deferred clear length", 32'(n), 256);
        fetch_miss(32'h0000_4448, "R8 filled line invalidated");
        fetch_hit(32'h0000_4440, "R8 refilled line hits");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_line();
        t_conflict();
        t_extremes();
        t_stray();
        t_inval();
        t_defer();
        finish_run();
    end

endmodule